// File: doc/BRIEF.md
# Cascadable Serial Position Shift Register

This block is the synchronous-serial output port for an absolute position word. A plain control level chooses between two modes. In capture mode the register takes in the parallel position word on every system clock cycle, and the serial output shows the word's top bit. In transfer mode each rising edge of an externally supplied serial clock moves the register one place toward the serial output, so the word leaves most significant bit first. An optional inversion input flips only the top bit of the captured word. This reverses the counting direction of the position code.

The far end of the register (bit 0) is fed from a serial data input. Tying that input to the output of another unit daisy-chains several units: after one word has left, the next unit's word follows with no gap. Tying the last unit's output back to the first unit's input turns the chain into a ring that repeats the transmission. The serial clock and the mode level are asynchronous to the system clock. Each goes through a two-flop synchronizer, and the serial clock's rising edge is detected internally. The serial pins have no valid/ready handshake and no back-pressure: the external master sets the pace through the pulses it gives. A bit is taken out by sampling while the serial clock is low. The serial data input must hold steady from the serial clock's rising edge until the shift has taken effect, which is three system cycles. A unit upstream in the chain meets this by construction.

Top module: `pos_serial_port`

## Requirements
- R1: While rst_n is low the shift register is cleared and sdata_out is 0.
- R2: While load_sel is 1 (capture mode), the register is reloaded from pos_word on every system cycle. sdata_out therefore shows the captured bit 15 and follows changes of pos_word.
- R3: With msb_flip at 1, the captured word has bit 15 inverted and bits 14..0 unchanged. With msb_flip at 0, the word is captured as is.
- R4: While load_sel is 0 (transfer mode), each rising edge of sclk_in moves the register one place toward sdata_out. Before pulse k (k counted from 0) sdata_out carries captured bit 15-k. Without a rising edge the register holds.
- R5: sdata_in enters at bit 0 on each shift. After 16 pulses the bits received on sdata_in reach sdata_out in the order they arrived, so chained units stream back to back and a closed ring repeats its content.
- R6: Once transfer mode is in effect, changes of pos_word and msb_flip have no effect on the word being sent.
- R7: Rising edges of sclk_in while load_sel is 1 do not move the register: sdata_out keeps showing the captured bit 15.
- R8: A change of load_sel or a rising edge of sclk_in takes effect at the third rising system clock edge after the input changes. sdata_out still holds the old value two edges after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_word | input | 16 | Parallel absolute position word |
| msb_flip | input | 1 | 1 inverts bit 15 of the captured word |
| load_sel | input | 1 | 1 selects capture mode, 0 selects transfer mode (asynchronous) |
| sclk_in | input | 1 | External serial clock; rising edges shift (asynchronous) |
| sdata_in | input | 1 | Serial cascade input entering at bit 0 |
| sdata_out | output | 1 | Serial data output, top bit of the register |

## Verification
The bench closes two units into a ring and streams 48 pulses. The data must read as word A, then word B, then word A again. A design that fed the cascade input into the wrong end, or dropped a bit between units, breaks the seam at bit 16 or bit 32. It also changes the parallel words after transfer mode has begun, which catches a design that keeps capturing. It pulses the serial clock while still in capture mode, which exposes a design that lets a shift win over the reload even for one cycle. It checks the exact cycle in which the first shift lands and confirms that a long idle pause moves nothing. A second pass with the inversion input set checks that only the top bit of each word changes.

// File: rtl/pos_serial_pkg.sv
package pos_serial_pkg;
  localparam int unsigned DEF_WORD_W      = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_TRANSFER = 1'b0,
    MODE_CAPTURE  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/pos_serial_sync.sv
module pos_serial_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pos_serial_edge.sv
module pos_serial_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level_in;
  end

  assign rise = level_in & ~level_d;

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pos_serial_core.sv
module pos_serial_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [W-1:0] word_in,
  input  logic         msb_flip,
  input  logic         ser_in,
  output logic         ser_out
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] sreg;
  logic [W-1:0] cap_word;

  always_comb begin
    cap_word      = word_in;
    cap_word[TOP] = word_in[TOP] ^ msb_flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (load_en)  sreg <= cap_word;
    else if (shift_en) sreg <= {sreg[W-2:0], ser_in};
  end

  assign ser_out = sreg[TOP];

  // R2
  capture_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ser_out == ($past(word_in[TOP]) ^ $past(msb_flip))));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(sreg));

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (sreg[W-1:1] == $past(sreg[W-2:0])));

  // R5
  cascade_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (sreg[0] == $past(ser_in)));
endmodule

// File: rtl/pos_serial_port.sv
module pos_serial_port
  import pos_serial_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pos_word,
  input  logic              msb_flip,
  input  logic              load_sel,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sdata_out
);
  logic [1:0] raw_ctl;
  logic [1:0] sync_ctl;
  logic       sclk_s;
  logic       sclk_rise;
  port_mode_e mode;
  logic       load_en;
  logic       shift_en;

  assign raw_ctl = {load_sel, sclk_in};

  pos_serial_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_ctl),
    .sync_out (sync_ctl)
  );

  assign sclk_s = sync_ctl[0];
  assign mode   = port_mode_e'(sync_ctl[1]);

  pos_serial_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (sclk_s),
    .rise     (sclk_rise)
  );

  assign load_en  = (mode == MODE_CAPTURE);
  assign shift_en = (mode == MODE_TRANSFER) && sclk_rise;

  pos_serial_core #(.W(WORD_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .word_in  (pos_word),
    .msb_flip (msb_flip),
    .ser_in   (sdata_in),
    .ser_out  (sdata_out)
  );

  // R7
  no_shift_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !shift_en);
endmodule

// File: tb/sim_pos_serial_port.sv
module sim_pos_serial_port;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_SCL   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_a = '0;
  logic [15:0] word_b = '0;
  logic        flip = 1'b0;
  logic        lsel = 1'b0;
  logic        sclk = 1'b0;
  logic        out0, out1;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  bit  mon_on   = 1'b0;
  string cur_req = "R4";
  bit  exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .pos_word(word_a), .msb_flip(flip),
    .load_sel(lsel), .sclk_in(sclk), .sdata_in(out1), .sdata_out(out0)
  );
  pos_serial_port u1 (
    .clk(clk), .rst_n(rst_n), .pos_word(word_b), .msb_flip(flip),
    .load_sel(lsel), .sclk_in(sclk), .sdata_in(out0), .sdata_out(out1)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_word(input logic [15:0] w, input bit inv);
    logic [15:0] c;
    c = w;
    c[15] = w[15] ^ inv;
    for (int i = 15; i >= 0; i--) exp_q.push_back(c[i]);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1;
    wait_neg(HALF_SCL);
    sclk = 1'b0;
    wait_neg(HALF_SCL);
  endtask

  // monitor: samples the stream just as SCL rises, while the data is still settled
  always @(posedge sclk) begin
    if (mon_on) begin
      if (exp_q.size() == 0) check("R5 queue underrun", 1'b1, 1'b0);
      else check(cur_req, out0, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_neg(3);
    // R1 reset state
    check("R1", out0, 1'b0);
    check("R1", out1, 1'b0);
    rst_n = 1'b1;
    wait_neg(2);
    check("R1", out0, 1'b0);

    // capture mode, latency R8
    word_a = 16'hB5C3;
    word_b = 16'h4E29;
    lsel   = 1'b1;
    wait_neg(2);
    check("R8", out0, 1'b0);
    wait_neg(1);
    check("R2", out0, 1'b1);
    check("R2", out1, 1'b0);
    // capture follows the word
    word_a = 16'h35C3;
    wait_neg(3);
    check("R2", out0, 1'b0);
    word_a = 16'hB5C3;
    wait_neg(3);
    check("R2", out0, 1'b1);

    // R7 SCL pulse in capture mode must not disturb the output
    sclk = 1'b1;
    for (int i = 0; i < HALF_SCL; i++) begin wait_neg(1); check("R7", out0, 1'b1); end
    sclk = 1'b0;
    for (int i = 0; i < HALF_SCL; i++) begin wait_neg(1); check("R7", out0, 1'b1); end

    // transfer: ring of two units, A then B then A again (R4, R5)
    lsel = 1'b0;
    wait_neg(6);
    push_word(16'hB5C3, 1'b0);
    push_word(16'h4E29, 1'b0);
    push_word(16'hB5C3, 1'b0);
    mon_on  = 1'b1;
    cur_req = "R4";
    // first pulse with latency check (R8): A = B5C3, bits 15,14 = 1,0
    sclk = 1'b1;
    wait_neg(2);
    check("R8", out0, 1'b1);
    wait_neg(1);
    check("R8", out0, 1'b0);
    wait_neg(HALF_SCL - 3);
    sclk = 1'b0;
    wait_neg(HALF_SCL);
    for (int i = 1; i < 20; i++) pulse();
    // long idle: nothing moves without an edge (R4)
    wait_neg(50);
    check("R4 idle", out0, exp_q[0]);
    cur_req = "R5";
    for (int i = 20; i < 48; i++) pulse();
    mon_on = 1'b0;
    check("R5 all bits consumed", exp_q.size() == 0, 1'b1);

    // second pass: inversion and freeze (R3, R6)
    flip   = 1'b1;
    word_a = 16'h0F0F;
    word_b = 16'h8001;
    lsel   = 1'b1;
    wait_neg(6);
    check("R3", out0, 1'b1);
    check("R3", out1, 1'b0);
    lsel = 1'b0;
    wait_neg(6);
    word_a = 16'hFFFF;
    word_b = 16'h0000;
    flip   = 1'b0;
    push_word(16'h0F0F, 1'b1);
    push_word(16'h8001, 1'b1);
    mon_on  = 1'b1;
    cur_req = "R3/R6";
    for (int i = 0; i < 32; i++) pulse();
    mon_on = 1'b0;
    check("R6 all bits consumed", exp_q.size() == 0, 1'b1);

    finish_run();
  end
endmodule